// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block sits behind the control pins of a flow-through synchronous burst SRAM. On every rising clock edge it samples chip enable, the two chip selects, the two address strobes, advance and the write controls. From these it decides whether the cycle is a deselect, the start of a burst, a continued burst or a suspended burst. It then issues the per-byte write strobes, the address-load and address-advance commands, and the enable for the read-data drivers. A small byte-writable array sits behind the controller, so that reads and writes can be seen at the ports.

Reads are flow-through. Once an edge has set the array address, the word appears on the read bus in that same cycle, with no output register. A burst covers four words within an aligned group of four. The low two address bits step in wrapping linear order by default. A parameter selects the XOR (interleaved) order instead. When the sleep input is high, the controller and the array hold their state and the read bus is not driven.

Top module: `burst_sram_ctl`

## Requirements
- R1: The part is selected only when `en_n`=0, `sel_hi`=1 and `sel_lo_n`=0. A cycle started by an active strobe while the part is not selected is a deselect: the read bus is undriven in the next cycle, and later strobe-free cycles issue no command until a new burst starts.
- R2: A cycle started by `strobe_proc_n`=0 while `en_n`=0 loads the address as a read, and no byte is written at that edge whatever the write controls are. Write controls given on the following strobe-free edge do write the current burst word.
- R3: `wr_all_n`=0 writes all four bytes of the addressed word and overrides `byte_wr_en_n` and `byte_sel_n`.
- R4: With `wr_all_n`=1 and `byte_wr_en_n`=0, bit i of `byte_sel_n` low writes byte i, which is data bits [9i+8:9i]. Any combination of bytes may be written in one cycle.
- R5: With `wr_all_n`=1 and `byte_wr_en_n`=1, the byte selects have no effect and no byte is written.
- R6: In an open burst, an edge with neither strobe active and `adv_n`=0 advances to the next word (`adv_o`=1). With `adv_n`=1 it stays on the current word. `en_n` has no effect on such an edge. `load_o` and `adv_o` are never high together.
- R7: In the default (linear) order, the low two address bits of a burst from base b are b, b+1, b+2, b+3, taken modulo 4. The upper bits stay fixed.
- R8: `rdata_o` shows the word at the current burst address in the cycle after the edge that set that address. `rdata_drv_o` is 1 only when `oe_n`=0, the part was selected at the last edge, no byte write was issued at that edge, and `sleep_i`=0.
- R9: While `sleep_i`=1, edges change neither the commands, the burst state nor the array, and the read bus is undriven. After a deselect cycle that follows sleep, the stored data reads back unchanged.
- R10: While `rst_n`=0, all write strobes, `load_o`, `adv_o` and `rdata_drv_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Sleep: freezes state, read bus undriven |
| en_n | input | 1 | Chip enable, active low; also gates `strobe_proc_n` |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| strobe_proc_n | input | 1 | Processor address strobe, active low, always starts a read |
| strobe_ctl_n | input | 1 | Controller address strobe, active low, starts a read or a write |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write of all bytes, active low |
| byte_wr_en_n | input | 1 | Enables the per-byte selects, active low |
| byte_sel_n | input | NBYTES | Per-byte write selects, active low |
| oe_n | input | 1 | Output enable, active low, combinational |
| addr_i | input | ADDR_W | Word address loaded on a burst start |
| wdata_i | input | NBYTES*BYTE_W | Write data, taken at the committing edge |
| byte_we_o | output | NBYTES | Bytes written at the last edge |
| load_o | output | 1 | Last edge loaded a new address |
| adv_o | output | 1 | Last edge advanced the burst |
| rdata_o | output | NBYTES*BYTE_W | Flow-through read word |
| rdata_drv_o | output | 1 | Read bus drive enable |

## Verification
The hardest case to reach is a write that follows a processor-strobe start. The write controls must be low on the start edge and must be ignored there, then take effect on the next strobe-free edge, against an address the bench has to follow through the burst counter. The stimulus holds global write low across a processor-strobe read at a base address of 2 modulo 4. It then suspends with new data, and advances until the low address bits wrap past 3. A second awkward case is entering sleep with strobes, advance and writes all active, then leaving sleep through a deselect and reading the stored word back.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   typedef enum logic [2:0] {
      CYC_IDLE,
      CYC_DESEL,
      CYC_BEGIN,
      CYC_CONT,
      CYC_SUSP
   } cyc_e;

   localparam int BURST_W   = 2;
   localparam int BURST_LEN = 1 << BURST_W;
endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
   import sbc_pkg::*;
#(
   parameter int NBYTES = 4
) (
   input  logic              en_n,
   input  logic              sel_hi,
   input  logic              sel_lo_n,
   input  logic              strobe_proc_n,
   input  logic              strobe_ctl_n,
   input  logic              adv_n,
   input  logic              wr_all_n,
   input  logic              byte_wr_en_n,
   input  logic [NBYTES-1:0] byte_sel_n,
   input  logic              burst_open,
   output cyc_e              cyc,
   output logic [NBYTES-1:0] wmask
);
   logic              picked;
   logic              proc_go;
   logic [NBYTES-1:0] intent;

   assign picked  = !en_n && sel_hi && !sel_lo_n;
   assign proc_go = !strobe_proc_n && !en_n;

   always_comb begin
      if (!wr_all_n)          intent = '1;
      else if (!byte_wr_en_n) intent = ~byte_sel_n;
      else                    intent = '0;
   end

   always_comb begin
      cyc   = CYC_IDLE;
      wmask = '0;
      if (proc_go) begin
         cyc = picked ? CYC_BEGIN : CYC_DESEL;
      end else if (!strobe_ctl_n) begin
         cyc   = picked ? CYC_BEGIN : CYC_DESEL;
         wmask = picked ? intent : '0;
      end else if (burst_open) begin
         cyc   = adv_n ? CYC_SUSP : CYC_CONT;
         wmask = intent;
      end
   end
endmodule

// File: rtl/sbc_burst_addr.sv
module sbc_burst_addr
   import sbc_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter bit INTERLEAVED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cyc_e              cyc,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [ADDR_W-1:0] nxt_addr
);
   logic [ADDR_W-1:0]  base_q, base_d;
   logic [BURST_W-1:0] cnt_q, cnt_d;
   logic [BURST_W-1:0] cur_lo, nxt_lo;

   always_comb begin
      base_d = base_q;
      cnt_d  = cnt_q;
      case (cyc)
         CYC_BEGIN: begin
            base_d = addr_i;
            cnt_d  = '0;
         end
         CYC_CONT: cnt_d = cnt_q + 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else begin
         base_q <= base_d;
         cnt_q  <= cnt_d;
      end
   end

   generate
      if (INTERLEAVED) begin : g_xor_order
         assign cur_lo = base_q[BURST_W-1:0] ^ cnt_q;
         assign nxt_lo = base_d[BURST_W-1:0] ^ cnt_d;
      end else begin : g_lin_order
         assign cur_lo = base_q[BURST_W-1:0] + cnt_q;
         assign nxt_lo = base_d[BURST_W-1:0] + cnt_d;
      end
   endgenerate

   assign cur_addr = {base_q[ADDR_W-1:BURST_W], cur_lo};
   assign nxt_addr = {base_d[ADDR_W-1:BURST_W], nxt_lo};
endmodule

// File: rtl/sbc_array.sv
module sbc_array #(
   parameter int ADDR_W = 6,
   parameter int NBYTES = 4,
   parameter int BYTE_W = 9
) (
   input  logic                     clk,
   input  logic [NBYTES-1:0]        we,
   input  logic [ADDR_W-1:0]        waddr,
   input  logic [NBYTES*BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]        raddr,
   output logic [NBYTES*BYTE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar b = 0; b < NBYTES; b++) begin : g_lane
         logic [BYTE_W-1:0] lane_mem [DEPTH];
         always_ff @(posedge clk) begin
            if (we[b]) lane_mem[waddr] <= wdata[b*BYTE_W +: BYTE_W];
         end
         assign rdata[b*BYTE_W +: BYTE_W] = lane_mem[raddr];
      end
   endgenerate
endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
   import sbc_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int NBYTES      = 4,
   parameter int BYTE_W      = 9,
   parameter bit INTERLEAVED = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sleep_i,
   input  logic                     en_n,
   input  logic                     sel_hi,
   input  logic                     sel_lo_n,
   input  logic                     strobe_proc_n,
   input  logic                     strobe_ctl_n,
   input  logic                     adv_n,
   input  logic                     wr_all_n,
   input  logic                     byte_wr_en_n,
   input  logic [NBYTES-1:0]        byte_sel_n,
   input  logic                     oe_n,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic [NBYTES*BYTE_W-1:0] wdata_i,
   output logic [NBYTES-1:0]        byte_we_o,
   output logic                     load_o,
   output logic                     adv_o,
   output logic [NBYTES*BYTE_W-1:0] rdata_o,
   output logic                     rdata_drv_o
);
   generate
      if (ADDR_W < BURST_W || ADDR_W > 12) begin : g_bad_addr
         $error("burst_sram_ctl: ADDR_W must lie in 2..12");
      end
      if (NBYTES < 1 || BYTE_W < 1) begin : g_bad_lane
         $error("burst_sram_ctl: NBYTES and BYTE_W must be positive");
      end
   endgenerate

   cyc_e              dec_cyc, eff_cyc;
   logic [NBYTES-1:0] dec_mask, eff_mask;
   logic [ADDR_W-1:0] cur_addr, nxt_addr;
   logic              open_q, sel_q, load_q, adv_q;
   logic [NBYTES-1:0] we_q;

   sbc_decode #(.NBYTES(NBYTES)) u_dec (
      .en_n         (en_n),
      .sel_hi       (sel_hi),
      .sel_lo_n     (sel_lo_n),
      .strobe_proc_n(strobe_proc_n),
      .strobe_ctl_n (strobe_ctl_n),
      .adv_n        (adv_n),
      .wr_all_n     (wr_all_n),
      .byte_wr_en_n (byte_wr_en_n),
      .byte_sel_n   (byte_sel_n),
      .burst_open   (open_q),
      .cyc          (dec_cyc),
      .wmask        (dec_mask)
   );

   assign eff_cyc  = sleep_i ? CYC_IDLE : dec_cyc;
   assign eff_mask = sleep_i ? '0 : dec_mask;

   sbc_burst_addr #(.ADDR_W(ADDR_W), .INTERLEAVED(INTERLEAVED)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .cyc     (eff_cyc),
      .addr_i  (addr_i),
      .cur_addr(cur_addr),
      .nxt_addr(nxt_addr)
   );

   sbc_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_mem (
      .clk  (clk),
      .we   (eff_mask),
      .waddr(nxt_addr),
      .wdata(wdata_i),
      .raddr(cur_addr),
      .rdata(rdata_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         sel_q  <= 1'b0;
         load_q <= 1'b0;
         adv_q  <= 1'b0;
         we_q   <= '0;
      end else if (!sleep_i) begin
         case (eff_cyc)
            CYC_DESEL: open_q <= 1'b0;
            CYC_BEGIN: open_q <= 1'b1;
            default:   ;
         endcase
         sel_q  <= (eff_cyc == CYC_BEGIN) || (eff_cyc == CYC_CONT) || (eff_cyc == CYC_SUSP);
         load_q <= (eff_cyc == CYC_BEGIN);
         adv_q  <= (eff_cyc == CYC_CONT);
         we_q   <= eff_mask;
      end
   end

   assign byte_we_o   = we_q;
   assign load_o      = load_q;
   assign adv_o       = adv_q;
   assign rdata_drv_o = !oe_n && sel_q && (we_q == '0) && !sleep_i;
endmodule

// File: rtl/burst_sram_ctl_chk.sv
module burst_sram_ctl_chk #(
   parameter int NBYTES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sleep_i,
   input logic              en_n,
   input logic              sel_hi,
   input logic              sel_lo_n,
   input logic              strobe_proc_n,
   input logic              strobe_ctl_n,
   input logic              wr_all_n,
   input logic              byte_wr_en_n,
   input logic [NBYTES-1:0] byte_we_o,
   input logic              load_o,
   input logic              adv_o,
   input logic              rdata_drv_o
);
   logic picked, proc_go;
   assign picked  = !en_n && sel_hi && !sel_lo_n;
   assign proc_go = !strobe_proc_n && !en_n;

   AST_UNSELECTED_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(!strobe_ctl_n && !picked && !sleep_i) |-> !rdata_drv_o); // R1

   AST_PROC_START_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(proc_go && !sleep_i) |-> byte_we_o == '0); // R2

   AST_GLOBAL_ALL_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(!proc_go && !strobe_ctl_n && picked && !wr_all_n && !sleep_i)
      |-> &byte_we_o); // R3

   AST_SELECTS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(wr_all_n && byte_wr_en_n) |-> byte_we_o == '0); // R5

   AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load_o, adv_o})); // R6

   AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(sleep_i)
      |-> $stable(byte_we_o) && $stable(load_o) && $stable(adv_o)); // R9
endmodule

bind burst_sram_ctl burst_sram_ctl_chk #(.NBYTES(NBYTES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sleep_i      (sleep_i),
   .en_n         (en_n),
   .sel_hi       (sel_hi),
   .sel_lo_n     (sel_lo_n),
   .strobe_proc_n(strobe_proc_n),
   .strobe_ctl_n (strobe_ctl_n),
   .wr_all_n     (wr_all_n),
   .byte_wr_en_n (byte_wr_en_n),
   .byte_we_o    (byte_we_o),
   .load_o       (load_o),
   .adv_o        (adv_o),
   .rdata_drv_o  (rdata_drv_o)
);

// File: tb/tb_burst_sram_ctl.sv
module tb_burst_sram_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sleep_i, en_n, sel_hi, sel_lo_n, strobe_proc_n, strobe_ctl_n, adv_n;
   logic        wr_all_n, byte_wr_en_n, oe_n;
   logic [3:0]  byte_sel_n;
   logic [5:0]  addr_i;
   logic [35:0] wdata_i;
   logic [3:0]  byte_we_o;
   logic        load_o, adv_o, rdata_drv_o;
   logic [35:0] rdata_o;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string req = "R10";

   // behavioural reference state
   bit          m_open = 1'b0, m_sel = 1'b0, m_load = 1'b0, m_adv = 1'b0;
   int          m_base = 0, m_cnt = 0;
   logic [3:0]  m_we = 4'h0;
   logic [35:0] m_mem  [int];
   logic [3:0]  m_mask [int];

   always #5 clk = ~clk;

   burst_sram_ctl dut (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .en_n(en_n), .sel_hi(sel_hi),
      .sel_lo_n(sel_lo_n), .strobe_proc_n(strobe_proc_n), .strobe_ctl_n(strobe_ctl_n),
      .adv_n(adv_n), .wr_all_n(wr_all_n), .byte_wr_en_n(byte_wr_en_n),
      .byte_sel_n(byte_sel_n), .oe_n(oe_n), .addr_i(addr_i), .wdata_i(wdata_i),
      .byte_we_o(byte_we_o), .load_o(load_o), .adv_o(adv_o), .rdata_o(rdata_o),
      .rdata_drv_o(rdata_drv_o)
   );

   function automatic int word_addr();
      return (m_base & 'h3c) | ((m_base + m_cnt) & 3);
   endfunction

   task automatic check(input string what, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic quiet();
      sleep_i = 0; en_n = 1; sel_hi = 1; sel_lo_n = 0; strobe_proc_n = 1; strobe_ctl_n = 1;
      adv_n = 1; wr_all_n = 1; byte_wr_en_n = 1; byte_sel_n = 4'hf; oe_n = 0;
      addr_i = 0; wdata_i = 0;
   endtask

   task automatic model_edge();
      bit picked, pgo;
      int kind;
      logic [3:0] intent, mask;
      if (sleep_i) return;
      picked = !en_n && sel_hi && !sel_lo_n;
      pgo    = !strobe_proc_n && !en_n;
      intent = !wr_all_n ? 4'hf : (!byte_wr_en_n ? ~byte_sel_n : 4'h0);
      mask   = 4'h0;
      kind   = 0;
      if (pgo || !strobe_ctl_n) begin
         if (picked) begin
            kind = 2; m_base = int'(addr_i); m_cnt = 0;
            if (!pgo) mask = intent;
         end else kind = 1;
      end else if (m_open) begin
         if (!adv_n) begin kind = 3; m_cnt = (m_cnt + 1) % 4; end
         else kind = 4;
         mask = intent;
      end
      if (mask != 0) begin
         int a = word_addr();
         if (!m_mem.exists(a)) begin m_mem[a] = '0; m_mask[a] = 4'h0; end
         for (int b = 0; b < 4; b++)
            if (mask[b]) m_mem[a][b*9 +: 9] = wdata_i[b*9 +: 9];
         m_mask[a] |= mask;
      end
      if (kind >= 2) m_open = 1'b1;
      else if (kind == 1) m_open = 1'b0;
      m_sel = (kind >= 2); m_we = mask; m_load = (kind == 2); m_adv = (kind == 3);
   endtask

   task automatic compare();
      logic exp_drv;
      exp_drv = !oe_n && m_sel && (m_we == 0) && !sleep_i;
      check("byte_we_o", 36'(byte_we_o), 36'(m_we));
      check("load_o", 36'(load_o), 36'(m_load));
      check("adv_o", 36'(adv_o), 36'(m_adv));
      check("rdata_drv_o", 36'(rdata_drv_o), 36'(exp_drv));
      if (exp_drv && m_mask.exists(word_addr())) begin
         logic [35:0] keep = '0;
         for (int b = 0; b < 4; b++)
            if (m_mask[word_addr()][b]) keep[b*9 +: 9] = '1;
         check("rdata_o", rdata_o & keep, m_mem[word_addr()] & keep);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_edge();
      #2;
      compare();
   endtask

   initial begin
      quiet();
      repeat (3) @(posedge clk);
      #2;
      req = "R10";
      check("reset byte_we_o", 36'(byte_we_o), 36'h0);
      check("reset load_o", 36'(load_o), 36'h0);
      check("reset adv_o", 36'(adv_o), 36'h0);
      check("reset rdata_drv_o", 36'(rdata_drv_o), 36'h0);
      rst_n = 1;

      // R3 global write burst from 8 with linear advance (R7)
      req = "R3";
      en_n = 0; strobe_ctl_n = 0; wr_all_n = 0; byte_wr_en_n = 0; byte_sel_n = 4'hf;
      addr_i = 6'd8; wdata_i = 36'h1_2345_6789; tick();
      req = "R7";
      strobe_ctl_n = 1; adv_n = 0; wdata_i = 36'h2_1111_1111; tick();
      wdata_i = 36'h3_2222_2222; tick();
      wdata_i = 36'h4_3333_3333; tick();
      req = "R6"; wr_all_n = 1; byte_wr_en_n = 1; adv_n = 1; tick();

      // R2 processor start ignores write, next edge writes; wrap from base 10 (R7)
      req = "R2";
      strobe_proc_n = 0; addr_i = 6'd10; wr_all_n = 0; wdata_i = 36'hF_FFFF_FFFF; tick();
      strobe_proc_n = 1; adv_n = 1; wdata_i = 36'h5_ABCD_EF01; tick();
      req = "R7";
      wr_all_n = 1; en_n = 1; adv_n = 0; tick(); tick(); tick();
      req = "R6"; adv_n = 1; tick(); tick();

      // R4 byte writes, two passes on one word
      req = "R4";
      en_n = 0; strobe_ctl_n = 0; addr_i = 6'd20; byte_wr_en_n = 0; byte_sel_n = 4'b1010;
      wdata_i = 36'h1_0203_0405; tick();
      strobe_ctl_n = 1; byte_sel_n = 4'b0101; wdata_i = 36'h6_0708_090A; tick();
      byte_wr_en_n = 1; byte_sel_n = 4'hf; tick();

      // R5 selects blocked
      req = "R5";
      byte_sel_n = 4'h0; wdata_i = 36'h0_0000_0000; tick(); tick();
      byte_sel_n = 4'hf;

      // R8 output enable
      req = "R8"; oe_n = 1; tick(); oe_n = 0; tick();

      // R1 deselect via each select pin
      req = "R1";
      strobe_ctl_n = 0; sel_hi = 0; tick();
      strobe_ctl_n = 1; sel_hi = 1; adv_n = 0; wr_all_n = 0; tick();
      wr_all_n = 1; adv_n = 1;
      strobe_proc_n = 0; addr_i = 6'd8; tick();
      strobe_proc_n = 1; sel_lo_n = 1; strobe_ctl_n = 0; tick();
      strobe_ctl_n = 1; sel_lo_n = 0; tick();

      // R9 sleep freezes everything
      req = "R9";
      strobe_proc_n = 0; addr_i = 6'd10; tick();
      strobe_proc_n = 1;
      sleep_i = 1; strobe_ctl_n = 0; addr_i = 6'd30; wr_all_n = 0; adv_n = 0;
      wdata_i = 36'h9_9999_9999; tick(); tick(); tick();
      sleep_i = 0; wr_all_n = 1; adv_n = 1; sel_hi = 0; tick();
      sel_hi = 1; strobe_ctl_n = 1; strobe_proc_n = 0; addr_i = 6'd10; tick();
      strobe_proc_n = 1; tick();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule